// File: doc/BRIEF.md
# Multi-Source Fault Response Controller

This controller sits between six digital fault-detect flags and the enable lines of three power functions: an H-bridge output stage, a charge pump and an analog supply rail. Every flag arrives already filtered, with hysteresis applied upstream. Each fault has its own status bit. It also has its own set of enables that it pulls low, and its own way of recovering.

There are three recovery rules:
- Undervoltage and overtemperature faults release as soon as their flag drops.
- Overcurrent and gate-drive-timeout faults hold for a fixed retry period and then release. If the flag is still high, the fault is detected again.
- A watchdog-expiry fault latches until firmware writes the clear-fault strobe.

Each enable is low while any fault that gates it is active. When faults overlap, an output returns only after every one of those faults has recovered. The controller's own logic keeps running under every fault condition.

Top module: `fault_response_ctrl`

## Requirements
- R1: While `rst` is sampled high, and after it is released with all flags low, `fault_status` is 0, all three enables are 1 and `fault_any` is 0.
- R2: The `fault_status` bit positions are: bit 0 supply undervoltage, bit 1 charge-pump undervoltage, bit 2 overcurrent, bit 3 gate-drive timeout, bit 4 watchdog expiry, bit 5 overtemperature. A flag sampled high at a rising edge sets its bit, which is visible after that edge.
- R3: Bits 0, 1 and 5 follow their flags with one cycle of lag. They clear at the first edge where the flag is sampled low.
- R4: Bits 2 and 3 stay set for exactly `RETRY_CYCLES` cycles, whatever the flag does. They then stay low for at least one cycle, and are set again at the next edge if the flag is still high.
- R5: Bit 4 stays set until `clr_fault` is sampled high while the watchdog flag is low. A clear strobe while the flag is high leaves the bit set.
- R6: `bridge_en` is 0 whenever any status bit is set, and 1 otherwise.
- R7: `pump_en` and `arail_en` are 0 exactly when bit 0 or bit 5 is set. Bits 1 to 4 have no effect on them.
- R8: `fault_any` is the OR of all six status bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flt_supply_uv | input | 1 | Main supply undervoltage flag |
| flt_pump_uv | input | 1 | Charge-pump output undervoltage flag |
| flt_overcur | input | 1 | Power-stage overcurrent flag |
| flt_gate_tmo | input | 1 | Gate-drive timeout flag |
| flt_wdog | input | 1 | Controller watchdog-expiry flag |
| flt_overtemp | input | 1 | Overtemperature flag |
| clr_fault | input | 1 | Clear-fault write strobe |
| bridge_en | output | 1 | H-bridge enable |
| pump_en | output | 1 | Charge-pump enable |
| arail_en | output | 1 | Analog supply rail enable |
| fault_status | output | 6 | Per-fault status bits (order in R2) |
| fault_any | output | 1 | Summary fault line |

## Verification
Some properties are checked on every cycle:
- Automatic-recovery bits track their flags one cycle later.
- A retry bit never stays high longer than the retry period, and rises only after its flag.
- The watchdog bit holds when no clear arrives.
- An overtemperature flag always drops the pump and rail enables.

Other behaviour only the bench scenarios can show:
- Exact gating of every enable under all 64 combinations of faults.
- The exact length of the retry window and the one-cycle gap before re-detection.
- The rule that a clear strobe is ignored while the watchdog flag is still high.

// File: rtl/frc_pkg.sv
package frc_pkg;

    localparam int NUM_FAULTS = 6;
    localparam int NUM_RAILS  = 3;

    // Fault indices; these equal the bit positions in fault_status.
    typedef enum logic [2:0] {
        F_SUPPLY_UV = 3'd0,
        F_PUMP_UV   = 3'd1,
        F_OVERCUR   = 3'd2,
        F_GATE_TMO  = 3'd3,
        F_WDOG      = 3'd4,
        F_OVERTEMP  = 3'd5
    } fault_id_e;

    // Rail indices inside a gating mask.
    localparam int RAIL_BRIDGE = 0;
    localparam int RAIL_PUMP   = 1;
    localparam int RAIL_ARAIL  = 2;

    typedef enum logic [1:0] {
        REC_AUTO  = 2'd0,
        REC_RETRY = 2'd1,
        REC_CLEAR = 2'd2
    } recovery_e;

    typedef struct packed {
        logic arail;
        logic pump;
        logic bridge;
    } rail_en_t;

    function automatic recovery_e recovery_of(input int idx);
        case (idx)
            int'(F_OVERCUR), int'(F_GATE_TMO): return REC_RETRY;
            int'(F_WDOG):                      return REC_CLEAR;
            default:                           return REC_AUTO;
        endcase
    endfunction

    // Which rails a given fault pulls low.
    function automatic logic [NUM_RAILS-1:0] rail_mask(input int idx);
        logic [NUM_RAILS-1:0] m;
        m = '0;
        m[RAIL_BRIDGE] = 1'b1;
        if (idx == int'(F_SUPPLY_UV) || idx == int'(F_OVERTEMP)) begin
            m[RAIL_PUMP]  = 1'b1;
            m[RAIL_ARAIL] = 1'b1;
        end
        return m;
    endfunction

endpackage

// File: rtl/frc_fault_cell.sv
module frc_fault_cell #(
    parameter frc_pkg::recovery_e KIND = frc_pkg::REC_AUTO,
    parameter int RETRY_CYCLES = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic flag,
    input  logic clr,
    output logic status
);
    localparam int CNT_W = (RETRY_CYCLES < 2) ? 1 : $clog2(RETRY_CYCLES + 1);

    generate
        if (KIND == frc_pkg::REC_AUTO) begin : g_auto
            logic st_q;
            wire  unused_clr = clr;

            always_ff @(posedge clk) begin
                if (rst) st_q <= 1'b0;
                else     st_q <= flag;
            end
            assign status = st_q;

            // R3
            auto_track_chk: assert property (@(posedge clk) disable iff (rst)
                1'b1 |=> (status == $past(flag)))
                else $error("auto recovery cell lost track of its flag");

        end else if (KIND == frc_pkg::REC_RETRY) begin : g_retry
            logic             st_q;
            logic [CNT_W-1:0] cnt_q;
            logic [CNT_W:0]   held_q;
            wire              unused_clr = clr;

            always_ff @(posedge clk) begin
                if (rst) begin
                    st_q  <= 1'b0;
                    cnt_q <= '0;
                end else if (!st_q) begin
                    if (flag) begin
                        st_q  <= 1'b1;
                        cnt_q <= CNT_W'(RETRY_CYCLES - 1);
                    end
                end else if (cnt_q == '0) begin
                    st_q <= 1'b0;
                end else begin
                    cnt_q <= cnt_q - 1'b1;
                end
            end
            assign status = st_q;

            // Checker counter: consecutive cycles the bit has been held.
            always_ff @(posedge clk) begin
                if (rst)         held_q <= '0;
                else if (status) held_q <= held_q + 1'b1;
                else             held_q <= '0;
            end

            // R4
            retry_window_chk: assert property (@(posedge clk) disable iff (rst)
                held_q <= (CNT_W+1)'(RETRY_CYCLES))
                else $error("retry fault held past its window");

            // R2
            retry_set_cause_chk: assert property (@(posedge clk) disable iff (rst)
                $rose(status) |-> $past(flag))
                else $error("retry fault set without its flag");

        end else begin : g_clear
            logic st_q;

            always_ff @(posedge clk) begin
                if (rst) st_q <= 1'b0;
                else     st_q <= flag | (st_q & ~clr);
            end
            assign status = st_q;

            // R5
            latch_hold_chk: assert property (@(posedge clk) disable iff (rst)
                (status && !clr) |=> status)
                else $error("latched fault dropped without a clear");

            // R5
            latch_idle_chk: assert property (@(posedge clk) disable iff (rst)
                (!status && !flag) |=> !status)
                else $error("latched fault set spontaneously");
        end
    endgenerate

endmodule

// File: rtl/frc_gate_combiner.sv
module frc_gate_combiner (
    input  logic [frc_pkg::NUM_FAULTS-1:0] status,
    output frc_pkg::rail_en_t              rail_en
);
    import frc_pkg::*;

    logic [NUM_RAILS-1:0] blocked;

    generate
        for (genvar r = 0; r < NUM_RAILS; r++) begin : g_rail
            logic [NUM_FAULTS-1:0] column;
            for (genvar f = 0; f < NUM_FAULTS; f++) begin : g_src
                localparam logic [NUM_RAILS-1:0] MASK = rail_mask(f);
                assign column[f] = status[f] & MASK[r];
            end
            assign blocked[r] = |column;
        end
    endgenerate

    always_comb begin
        rail_en.bridge = ~blocked[RAIL_BRIDGE];
        rail_en.pump   = ~blocked[RAIL_PUMP];
        rail_en.arail  = ~blocked[RAIL_ARAIL];
    end

endmodule

// File: rtl/fault_response_ctrl.sv
module fault_response_ctrl #(
    parameter int RETRY_CYCLES = 8
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       flt_supply_uv,
    input  logic       flt_pump_uv,
    input  logic       flt_overcur,
    input  logic       flt_gate_tmo,
    input  logic       flt_wdog,
    input  logic       flt_overtemp,
    input  logic       clr_fault,
    output logic       bridge_en,
    output logic       pump_en,
    output logic       arail_en,
    output logic [5:0] fault_status,
    output logic       fault_any
);
    import frc_pkg::*;

    logic [NUM_FAULTS-1:0] flags;
    logic [NUM_FAULTS-1:0] status;
    rail_en_t              rail_en;

    always_comb begin
        flags[F_SUPPLY_UV] = flt_supply_uv;
        flags[F_PUMP_UV]   = flt_pump_uv;
        flags[F_OVERCUR]   = flt_overcur;
        flags[F_GATE_TMO]  = flt_gate_tmo;
        flags[F_WDOG]      = flt_wdog;
        flags[F_OVERTEMP]  = flt_overtemp;
    end

    generate
        for (genvar i = 0; i < NUM_FAULTS; i++) begin : g_cell
            frc_fault_cell #(
                .KIND         (recovery_of(i)),
                .RETRY_CYCLES (RETRY_CYCLES)
            ) u_cell (
                .clk    (clk),
                .rst    (rst),
                .flag   (flags[i]),
                .clr    (clr_fault),
                .status (status[i])
            );
        end
    endgenerate

    frc_gate_combiner u_comb (
        .status  (status),
        .rail_en (rail_en)
    );

    assign bridge_en    = rail_en.bridge;
    assign pump_en      = rail_en.pump;
    assign arail_en     = rail_en.arail;
    assign fault_status = status;
    assign fault_any    = |status;

    // R7
    overtemp_rails_chk: assert property (@(posedge clk) disable iff (rst)
        flt_overtemp |=> (!pump_en && !arail_en && !bridge_en))
        else $error("overtemperature did not drop pump and rail");

    // R6
    bridge_any_chk: assert property (@(posedge clk) disable iff (rst)
        fault_any |-> !bridge_en)
        else $error("bridge enabled during a fault");

    // R7
    pump_rail_pair_chk: assert property (@(posedge clk) disable iff (rst)
        pump_en == arail_en)
        else $error("pump and rail enables diverged");

endmodule

// File: tb/fault_response_ctrl_bench.sv
module fault_response_ctrl_bench;
    localparam int RC = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [5:0] flg = '0;
    logic clr = 1'b0;
    logic bridge_en, pump_en, arail_en, fault_any;
    logic [5:0] fault_status;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    fault_response_ctrl #(.RETRY_CYCLES(RC)) u_fault_response_ctrl (
        .clk(clk), .rst(rst),
        .flt_supply_uv(flg[0]), .flt_pump_uv(flg[1]), .flt_overcur(flg[2]),
        .flt_gate_tmo(flg[3]), .flt_wdog(flg[4]), .flt_overtemp(flg[5]),
        .clr_fault(clr),
        .bridge_en(bridge_en), .pump_en(pump_en), .arail_en(arail_en),
        .fault_status(fault_status), .fault_any(fault_any)
    );

    task automatic check_bit(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0b expected %0b", req, act, exp);
        end
    endtask

    // Compare all outputs against values computed from an expected status word.
    task automatic check_all(input string tag, input logic [5:0] exp_st);
        checks++;
        if (fault_status !== exp_st) begin
            errors++;
            $display("FAIL R2 %s status actual %b expected %b", tag, fault_status, exp_st);
        end
        check_bit({"R6 bridge ", tag}, bridge_en, exp_st == 6'd0);
        check_bit({"R7 pump ", tag},   pump_en,   !(exp_st[0] | exp_st[5]));
        check_bit({"R7 rail ", tag},   arail_en,  !(exp_st[0] | exp_st[5]));
        check_bit({"R8 any ", tag},    fault_any, exp_st != 6'd0);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; flg = '0; clr = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        // R1: reset state, even with flags asserted during reset
        @(negedge clk);
        flg = 6'h3f;
        @(negedge clk);
        check_all("R1 in reset", 6'd0);
        flg = '0;
        rst = 1'b0;
        @(negedge clk);
        check_all("R1 after reset", 6'd0);

        // Exhaustive sweep over all fault combinations
        for (int p = 0; p < 64; p++) begin
            do_reset();
            flg = 6'(p);
            @(negedge clk);
            check_all("R2 set", 6'(p));
            flg = '0;
            @(negedge clk);
            // R3 auto bits clear; R4 retry and R5 latched bits remain
            check_all("R3 R4 R5 flags low", 6'(p) & 6'b011100);
            clr = 1'b1;
            @(negedge clk);
            clr = 1'b0;
            check_all("R5 after clear", 6'(p) & 6'b001100);
        end

        // R4: single-cycle overcurrent pulse holds for exactly RC cycles
        do_reset();
        flg[2] = 1'b1;
        @(negedge clk);
        flg[2] = 1'b0;
        begin
            int high = 0;
            while (fault_status[2] && high < 3 * RC) begin
                high++;
                @(negedge clk);
            end
            checks++;
            if (high != RC) begin
                errors++;
                $display("FAIL R4 retry length actual %0d expected %0d", high, RC);
            end
        end
        check_all("R4 released", 6'd0);

        // R4: gate timeout flag held high -> RC high, one low, high again
        do_reset();
        flg[3] = 1'b1;
        for (int c = 0; c < RC; c++) begin
            @(negedge clk);
            check_all("R4 held window", 6'b001000);
        end
        @(negedge clk);
        check_all("R4 gap", 6'd0);
        @(negedge clk);
        check_all("R4 redetect", 6'b001000);
        flg[3] = 1'b0;

        // R5: clear while the watchdog flag is still high is ignored
        do_reset();
        flg[4] = 1'b1;
        clr = 1'b1;
        @(negedge clk);
        check_all("R5 clear with flag high", 6'b010000);
        @(negedge clk);
        check_all("R5 clear with flag high 2", 6'b010000);
        flg[4] = 1'b0;
        clr = 1'b0;
        for (int c = 0; c < 20; c++) @(negedge clk);
        check_all("R5 latched without clear", 6'b010000);
        clr = 1'b1;
        @(negedge clk);
        clr = 1'b0;
        check_all("R5 cleared", 6'd0);

        // R3 R7: overlapping supply UV and overtemp release only when both drop
        do_reset();
        flg = 6'b100001;
        @(negedge clk);
        flg = 6'b100000;
        @(negedge clk);
        check_all("R7 overlap one left", 6'b100000);
        flg = 6'b000000;
        @(negedge clk);
        check_all("R3 overlap released", 6'd0);

        finish_run();
    end
endmodule